// File: doc/BRIEF.md
# Pulse-Handshake FIFO with Level Flags

This block is a 64-word by 9-bit first-in first-out buffer. It is driven by a pulse handshake rather than by plain read and write enables. A producer places a word on `din` and pulses `shift_in`, and the word is captured when that line falls. A consumer waits for `out_ready` and reads the head word on `dout`. It then pulses `shift_out`, and the falling edge of that line discards the head and brings the next word forward. `in_ready` shows whether there is room for another word.

Both shift lines may come from slower or unrelated logic. Each passes through a two-flop synchroniser and an edge detector, all clocked by the single system clock. A word written into an empty buffer falls straight through to `dout`, and no shift out is needed to see it. Two status outputs report the fill level: a half-full flag, and one zone flag that is high both when the buffer is nearly empty and when it is nearly full. An output enable can float the data outputs without disturbing anything else. A synchronous master reset empties the buffer.

Top module: `shift_fifo`

## Requirements
- R1: The buffer holds up to 64 words of 9 bits, and words leave in the same order they were accepted.
- R2: A word is written only on a high-to-low transition of `shift_in`, and each such transition writes exactly one word. A rising transition has no effect. Each level of a shift pulse must be held for at least 3 clocks.
- R3: While 64 words are held, `in_ready` is low and a falling `shift_in` is ignored. The count and the stored data do not change.
- R4: A falling `shift_out` removes the head word. `out_ready` is low in the clock cycle that follows the removal. It returns high one cycle later if at least one word remains, and `dout` then shows the next word.
- R5: While the buffer is empty, `out_ready` is low and a falling `shift_out` is ignored.
- R6: A word written into an empty buffer appears on `dout`, and `out_ready` rises without any shift out. The clock edge that writes the word is the third edge that samples `shift_in` low, and `out_ready` is high right after that edge.
- R7: `level_zone` is high exactly when the word count is 8 or fewer, or 56 or more.
- R8: `half_full` is high exactly when the word count is 32 or more.
- R9: A clock edge with `rst` high empties the buffer. After it, `out_ready` and `half_full` are low, and `in_ready` and `level_zone` are high.
- R10: When falling edges of `shift_in` and `shift_out` are detected in the same cycle on a non-empty, non-full buffer, both take effect. The count is unchanged, and the order is kept.
- R11: With `oe` low, `dout` is high impedance, so another driver on the net sets its value. The stored words, `out_ready` and the flags are unaffected.
- R12: After a word is removed from a full buffer, `in_ready` is high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high master reset |
| shift_in | input | 1 | Write pulse; its falling edge captures `din` |
| din | input | 9 | Word to write |
| in_ready | output | 1 | High when a word can be accepted |
| shift_out | input | 1 | Read pulse; its falling edge removes the head word |
| dout | inout | 9 | Head word, or high impedance while `oe` is low |
| out_ready | output | 1 | High while a valid head word is on `dout` |
| oe | input | 1 | Output enable for `dout` |
| half_full | output | 1 | Word count is 32 or more |
| level_zone | output | 1 | Word count is 8 or fewer, or 56 or more |

## Verification
Several properties are checked on every cycle by the assertions:
- at most one write or read per detected pulse edge;
- no count change when a write meets a full buffer or a read meets an empty one;
- a steady count when a read and a write land in the same cycle;
- the forced gap in `out_ready` after every removal;
- the flags changing state only at their threshold counts;
- the empty state after reset.

Other behaviour can only be shown by the bench's scenarios:
- that data leaves in write order, including words moved by simultaneous shifts;
- that a write refused when full never shows up later;
- that fall-through happens with the exact latency;
- that a floated `dout` hands the net to another driver while the stored words survive.

// File: rtl/hsf_pkg.sv
package hsf_pkg;

    localparam int HSF_WIDTH    = 9;
    localparam int HSF_DEPTH    = 64;
    localparam int HSF_HF_LEVEL = 32;
    localparam int HSF_AF_LEVEL = 56;
    localparam int HSF_AE_LEVEL = 8;
    localparam int HSF_SYNC     = 2;

    // Fill-level status derived from the word count
    typedef struct packed {
        logic room;       // space for one more word
        logic half;       // at or above half-full threshold
        logic zone;       // near empty or near full
    } level_t;

    // Operations granted by the storage in one cycle
    typedef struct packed {
        logic wr;
        logic rd;
    } grant_t;

    function automatic logic in_zone(input int cnt, input int lo, input int hi);
        return (cnt <= lo) || (cnt >= hi);
    endfunction

endpackage

// File: rtl/hsf_edge_sync.sv
module hsf_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b0;
        else     last <= chain[STAGES-1];
    end

    assign fall = last && !chain[STAGES-1];

    // R2: a detected edge lasts a single cycle, so one pulse moves one word
    p_single_edge_r2: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);

endmodule

// File: rtl/hsf_store.sv
module hsf_store #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_req,
    input  logic                       rd_req,
    input  logic [WIDTH-1:0]           wdata,
    output logic [WIDTH-1:0]           head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output hsf_pkg::grant_t            grant
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             full, empty;

    assign full  = (count == FULL_CNT);
    assign empty = (count == '0);

    assign grant.wr = wr_req && !full;
    assign grant.rd = rd_req && !empty;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        if (p == AW'(DEPTH-1)) return '0;
        return p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (grant.wr) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (grant.wr) wr_ptr <= bump(wr_ptr);
            if (grant.rd) rd_ptr <= bump(rd_ptr);
            case ({grant.wr, grant.rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head = mem[rd_ptr];

    // R3: a write against a full buffer changes nothing
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (full && !grant.rd) |=> (count == FULL_CNT));

    // R5: a read against an empty buffer changes nothing
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
        (empty && !grant.wr) |=> (count == '0));

    // R10: a write and a read in one cycle keep the count
    p_both_keep_r10: assert property (@(posedge clk) disable iff (rst)
        (grant.wr && grant.rd) |=> $stable(count));

    // R9: reset leaves an empty buffer
    p_reset_empty_r9: assert property (@(posedge clk)
        rst |=> (count == '0));

    // R1: capacity bound
    always_comb begin
        if (!rst) p_cap_r1: assert (count <= FULL_CNT);
    end

endmodule

// File: rtl/hsf_flags.sv
module hsf_flags #(
    parameter int DEPTH    = 64,
    parameter int HF_LEVEL = 32,
    parameter int AF_LEVEL = 56,
    parameter int AE_LEVEL = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    output hsf_pkg::level_t            level
);
    localparam int CW = $clog2(DEPTH+1);

    always_comb begin
        level.room = (int'(count) < DEPTH);
        level.half = (int'(count) >= HF_LEVEL);
        level.zone = hsf_pkg::in_zone(int'(count), AE_LEVEL, AF_LEVEL);
    end

    // R8: half flag rises only on reaching the threshold
    p_half_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(level.half) |-> (count == CW'(HF_LEVEL)));

    // R7: zone flag drops only on leaving the low or high band
    p_zone_fall_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(level.zone) |-> (count == CW'(AE_LEVEL + 1) || count == CW'(AF_LEVEL - 1)));

    // R12: room returns one word below full
    p_room_back_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(level.room) |-> (count == CW'(DEPTH - 1)));

endmodule

// File: rtl/hsf_present.sv
module hsf_present (
    input  logic clk,
    input  logic rst,
    input  logic has_word,
    input  logic took,
    output logic valid
);
    logic settle;

    always_ff @(posedge clk) begin
        if (rst) settle <= 1'b0;
        else     settle <= took;
    end

    assign valid = has_word && !settle;

    // R4: after a removal the ready indication drops for a cycle
    p_ready_gap_r4: assert property (@(posedge clk) disable iff (rst)
        took |=> !valid);

    // R9: ready is low straight after reset
    p_ready_reset_r9: assert property (@(posedge clk)
        rst |=> !valid);

endmodule

// File: rtl/shift_fifo.sv
module shift_fifo #(
    parameter int WIDTH    = hsf_pkg::HSF_WIDTH,
    parameter int DEPTH    = hsf_pkg::HSF_DEPTH,
    parameter int HF_LEVEL = hsf_pkg::HSF_HF_LEVEL,
    parameter int AF_LEVEL = hsf_pkg::HSF_AF_LEVEL,
    parameter int AE_LEVEL = hsf_pkg::HSF_AE_LEVEL,
    parameter int SYNC     = hsf_pkg::HSF_SYNC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_in,
    input  logic [WIDTH-1:0] din,
    output logic             in_ready,
    input  logic             shift_out,
    inout  wire  [WIDTH-1:0] dout,
    output logic             out_ready,
    input  logic             oe,
    output logic             half_full,
    output logic             level_zone
);
    localparam int CW = $clog2(DEPTH+1);

    logic             wr_edge, rd_edge;
    logic [WIDTH-1:0] head;
    logic [CW-1:0]    count;
    hsf_pkg::grant_t  grant;
    hsf_pkg::level_t  level;

    hsf_edge_sync #(.STAGES(SYNC)) u_wr_sync (
        .clk(clk), .rst(rst), .pin(shift_in), .fall(wr_edge));

    hsf_edge_sync #(.STAGES(SYNC)) u_rd_sync (
        .clk(clk), .rst(rst), .pin(shift_out), .fall(rd_edge));

    hsf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .wr_req(wr_edge), .rd_req(rd_edge),
        .wdata(din), .head(head), .count(count), .grant(grant));

    hsf_flags #(.DEPTH(DEPTH), .HF_LEVEL(HF_LEVEL), .AF_LEVEL(AF_LEVEL),
                .AE_LEVEL(AE_LEVEL)) u_flags (
        .clk(clk), .rst(rst), .count(count), .level(level));

    hsf_present u_present (
        .clk(clk), .rst(rst), .has_word(count != '0), .took(grant.rd),
        .valid(out_ready));

    assign in_ready   = level.room;
    assign half_full  = level.half;
    assign level_zone = level.zone;
    assign dout       = oe ? head : {WIDTH{1'bz}};

    // R6: a write into an empty buffer makes data ready on the next cycle
    p_fall_through_r6: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && grant.wr && !grant.rd) |=> out_ready);

    // R3: no write is granted while room is gone
    p_full_block_r3: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> !grant.wr);

endmodule

// File: tb/shift_fifo_test.sv
module shift_fifo_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       shift_in, shift_out, oe;
    logic [8:0] din;
    wire  [8:0] dout;
    logic       in_ready, out_ready, half_full, level_zone;
    logic       drv_en;
    logic [8:0] drv_val;

    int total = 0;
    int bad   = 0;
    int n     = 0;
    logic [8:0] exp_q[$];
    logic prev_or = 1'b0;

    always #10 clk = ~clk;

    assign dout = drv_en ? drv_val : 9'bz;

    shift_fifo uut (
        .clk(clk), .rst(rst), .shift_in(shift_in), .din(din),
        .in_ready(in_ready), .shift_out(shift_out), .dout(dout),
        .out_ready(out_ready), .oe(oe), .half_full(half_full),
        .level_zone(level_zone));

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: whenever a new head word becomes ready, compare with the scoreboard
    always @(negedge clk) begin
        if (rst) begin
            prev_or <= 1'b0;
        end else begin
            if (out_ready && !prev_or && !drv_en) begin
                if (exp_q.size() == 0) chk("R1 unexpected word", 9'h0, 9'h1);
                else                   chk("R1 order", dout, exp_q[0]);
            end
            prev_or <= out_ready;
        end
    end

    task automatic status(input string req);
        chk({req, " in_ready"},   {8'h0, in_ready},   {8'h0, n < 64});
        chk({req, " half_full"},  {8'h0, half_full},  {8'h0, n >= 32});
        chk({req, " level_zone"}, {8'h0, level_zone}, {8'h0, (n <= 8) || (n >= 56)});
        chk({req, " out_ready"},  {8'h0, out_ready},  {8'h0, n > 0});
    endtask

    // Driver: write one word and update the scoreboard when it is accepted
    task automatic push(input logic [8:0] val);
        logic ok, was_empty;
        @(negedge clk);
        ok = in_ready;
        was_empty = (n == 0);
        din = val;
        shift_in = 1'b1;
        repeat (3) @(negedge clk);
        if (was_empty) chk("R2 rising edge no write", {8'h0, out_ready}, 9'h0);
        shift_in = 1'b0;
        if (ok) begin exp_q.push_back(val); n++; end
        repeat (2) @(negedge clk);
        if (was_empty) chk("R6 not yet ready", {8'h0, out_ready}, 9'h0);
        @(negedge clk);
        if (was_empty) chk("R6 fall-through ready", {8'h0, out_ready}, 9'h1);
        @(negedge clk);
    endtask

    task automatic pop();
        logic had;
        @(negedge clk);
        had = (n > 0);
        shift_out = 1'b1;
        repeat (3) @(negedge clk);
        shift_out = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 ready gap / R5 empty", {8'h0, out_ready}, 9'h0);
        if (had) begin void'(exp_q.pop_front()); n--; end
        @(negedge clk);
        chk("R4 ready after removal", {8'h0, out_ready}, {8'h0, n > 0});
        if (n > 0) chk("R4 next word", dout, exp_q[0]);
    endtask

    task automatic both(input logic [8:0] val);
        @(negedge clk);
        din = val;
        shift_in = 1'b1;
        shift_out = 1'b1;
        repeat (3) @(negedge clk);
        shift_in = 1'b0;
        shift_out = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 read took effect", {8'h0, out_ready}, 9'h0);
        void'(exp_q.pop_front());
        exp_q.push_back(val);
        @(negedge clk);
        status("R10");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; shift_in = 1'b0; shift_out = 1'b0; oe = 1'b1;
        din = '0; drv_en = 1'b0; drv_val = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        status("R9 reset");

        // R5: read on an empty buffer is ignored
        pop();
        status("R5 empty");

        // R6 then R7/R8/R3 while filling to 64
        for (int i = 0; i < 64; i++) begin
            push(9'((i * 37 + 5) & 9'h1ff));
            status("R7 R8 fill");
        end

        // R3: write to a full buffer is ignored
        push(9'h0AA);
        status("R3 full ignore");

        // R12: room returns after one removal
        pop();
        chk("R12 in_ready", {8'h0, in_ready}, 9'h1);
        status("R12");

        // drain down to 40, then simultaneous shifts
        while (n > 40) begin pop(); status("R7 R8 drain"); end
        both(9'h155);
        both(9'h0F0);

        // drain everything, checking order (R1)
        while (n > 0) begin pop(); status("R1 drain"); end
        pop();
        status("R5 empty again");

        // R11: output enable
        push(9'h123);
        push(9'h0C3);
        @(negedge clk);
        oe = 1'b0;
        drv_val = 9'h1A5;
        drv_en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 floated dout", dout, 9'h1A5);
        status("R11 flags unaffected");
        drv_en = 1'b0;
        oe = 1'b1;
        @(negedge clk);
        chk("R11 data kept", dout, 9'h123);
        pop();
        pop();
        status("R11 drained");

        // R9: reset while holding words
        for (int i = 0; i < 10; i++) push(9'(i + 300));
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_q.delete();
        n = 0;
        @(negedge clk);
        status("R9 mid reset");
        push(9'h077);
        chk("R9 first after reset", dout, 9'h077);
        pop();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule